// File: doc/BRIEF.md
# Strap-Configured Serial Register Port

This block lets a host reach a byte-wide register bank over a four-wire serial link (clock, select, data in, data out). It has no programmable configuration. Three things are fixed by strap inputs and taken on the last clock cycle of reset:
- whether the serial port is active at all;
- the idle level of the serial clock;
- which clock edge moves data.

The same straps also fix the active level of the chip select. Later changes on the straps have no effect until the next reset.

Each transfer is one select window holding two bytes, sent most significant bit first. The first byte is a header. Its top bit marks a read (1) or a write (0), and the remaining bits are the register address. On a write, the second byte is the data to store. On a read, the block shifts the addressed register out on the data-out line during the second byte. The serial clock, select and data input are brought into the system clock domain through flop synchronisers, and edges are found there. The data-out driver is enabled only while the select is active.

Top module: `strap_spi_regport`

## Requirements
- R1: `ser_sel` is 1 only when, on the last reset cycle, `strap_mode` was 00 and both `strap_rd_n` and `strap_wr_n` were 0. While `ser_sel` is 0, all serial traffic is ignored: `spi_miso_oe` stays 0 and no register is written.
- R2: `strap_cfg[0]` gives the idle level of `spi_sclk`. The leading edge is the one that leaves that level, and the trailing edge is the one that returns to it.
- R3: When `strap_cfg[1]` is 0, data is sampled on leading edges and changed on trailing edges. The first output bit is present as soon as select becomes active. When `strap_cfg[1]` is 1, data is changed on leading edges and sampled on trailing edges.
- R4: `strap_cfg[2]` is the active level of `spi_cs` (1 means active high).
- R5: The strap values are held from the last reset cycle. Strap changes after reset has been released have no effect.
- R6: Header byte: bit 7 = 1 for a read and 0 for a write; bits 6..0 are the address. On a write, the second byte is stored at that address once the sixteenth bit is sampled.
- R7: During the header, `spi_miso` is 0. During the second byte of a read, it carries the addressed register, most significant bit first. During the second byte of a write, it is 0.
- R8: `spi_miso_oe` is 0 whenever select is inactive. It is 1 within a few system clocks after select becomes active in serial mode.
- R9: If select goes inactive before sixteen bits have been sampled, the partial frame is discarded: no register changes, and the next frame starts at bit 0.
- R10: Bits clocked after the sixteenth within one select window are ignored. The register written is the one the first sixteen bits describe.
- R11: While reset is held, `spi_miso_oe` and `spi_miso` are 0. The register bank is not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_mode | input | 2 | Interface-mode strap; 00 is needed for serial operation |
| strap_rd_n | input | 1 | Read-strobe level at reset; 0 is needed for serial operation |
| strap_wr_n | input | 1 | Write-strobe level at reset; 0 is needed for serial operation |
| strap_cfg | input | 3 | Bit 0 idle clock level, bit 1 clock phase, bit 2 select active level |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select from the host, polarity set by strap_cfg[2] |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the spi_miso driver |
| ser_sel | output | 1 | Serial mode was selected at reset |

## Verification
The hardest situation to reach is a correct hand-off from the header to the read data in all eight strap combinations. Whether the first data bit appears on time depends on the phase setting, on the idle level and on the synchroniser delay, all together. The stimulus re-enters reset once for every strap combination and then runs random reads and writes at varied serial half-periods. Directed frames check three corner cases: a frame cut short at two different depths, a frame that overruns sixteen bits, and strap inputs that change after reset. In each case the register contents are read back through the port afterwards.

// File: rtl/spi_strap_pkg.sv
package spi_strap_pkg;
  // Strap word as presented on strap_cfg: bit 2 select level, bit 1 phase, bit 0 idle level.
  typedef struct packed {
    logic cs_high;
    logic cpha;
    logic cpol;
  } strap_cfg_t;

  localparam int unsigned STRAP_W = 3;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import spi_strap_pkg::*;
#(
  parameter int unsigned MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_strap,
  input  logic              rd_strap_n,
  input  logic              wr_strap_n,
  input  logic [STRAP_W-1:0] cfg_strap,
  output logic              ser_sel,
  output strap_cfg_t        cfg
);
  // Straps are followed while reset is high, so the last reset cycle wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      ser_sel <= (mode_strap == '0) && !rd_strap_n && !wr_strap_n;
      cfg     <= strap_cfg_t'(cfg_strap);
    end
  end

  AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(cfg) && $stable(ser_sel))) else $error("straps moved"); // R5
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= rst_val;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= rst_val;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single write port, registered read port: maps onto block RAM, no reset.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_strap_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  strap_cfg_t        cfg,
  input  logic              sclk_s,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rdata,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              miso,
  output logic              miso_oe
);
  localparam int unsigned HDR_W   = ADDR_W + 1;
  localparam int unsigned FRAME_W = HDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam int unsigned RX_W    = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FRM_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LOAD_PTR = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] OCNT_MAX = CNT_W'(FRAME_W + 1);

  logic              cs_act, lvl, lvl_d, lead, trail, smp, shf;
  logic [CNT_W-1:0]  cnt, ocnt, nptr;
  logic [RX_W-1:0]   rx_sr;
  logic [DATA_W-1:0] tx_sr, rd_hold;
  logic [HDR_W-1:0]  hdr_now;
  logic [DATA_W-1:0] wd_now;
  logic [ADDR_W-1:0] addr_q;
  logic              is_rd, re_d;

  always_comb begin
    cs_act  = en && (cs_s == cfg.cs_high);
    lvl     = sclk_s ^ cfg.cpol;            // 0 = idle level whatever the polarity
    lead    = cs_act && lvl && !lvl_d;
    trail   = cs_act && !lvl && lvl_d;
    smp     = cfg.cpha ? trail : lead;
    shf     = cfg.cpha ? lead : trail;
    // Stream position of the bit shown after this shift event.
    nptr    = cfg.cpha ? ocnt : ocnt + 1'b1;
    hdr_now = {rx_sr[HDR_W-2:0], mosi_s};
    wd_now  = {rx_sr[DATA_W-2:0], mosi_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d   <= 1'b0;
      cnt     <= '0;
      ocnt    <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rd_hold <= '0;
      addr_q  <= '0;
      is_rd   <= 1'b0;
      re      <= 1'b0;
      re_d    <= 1'b0;
      raddr   <= '0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
      miso_oe <= 1'b0;
    end else begin
      lvl_d   <= lvl;
      re      <= 1'b0;
      we      <= 1'b0;
      re_d    <= re;
      miso_oe <= cs_act;
      if (re_d) rd_hold <= rdata;
      if (!cs_act) begin
        cnt   <= '0;
        ocnt  <= '0;
        tx_sr <= '0;
        is_rd <= 1'b0;
      end else begin
        if (smp && cnt != FRM_FULL) begin
          rx_sr <= {rx_sr[RX_W-2:0], mosi_s};
          cnt   <= cnt + 1'b1;
          if (cnt == HDR_LAST) begin
            is_rd  <= hdr_now[HDR_W-1];
            addr_q <= hdr_now[ADDR_W-1:0];
            if (hdr_now[HDR_W-1]) begin
              re    <= 1'b1;
              raddr <= hdr_now[ADDR_W-1:0];
            end else begin
              rd_hold <= '0;
            end
          end
          if (cnt == FRM_LAST && !is_rd) begin
            we    <= 1'b1;
            waddr <= addr_q;
            wdata <= wd_now;
          end
        end
        if (shf) begin
          if (ocnt != OCNT_MAX) ocnt <= ocnt + 1'b1;
          if (nptr == LOAD_PTR) tx_sr <= rd_hold;
          else                  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sr[DATA_W-1];

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !miso_oe) else $error("oe while deselected"); // R8
  AST_CLEAR_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (cnt == '0 && ocnt == '0 && !miso)) else $error("stale frame state"); // R9
  AST_WRITE_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    we |-> (cnt == FRM_FULL && !is_rd)) else $error("early write"); // R6
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= FRM_FULL) else $error("count overrun"); // R10
endmodule

// File: rtl/strap_spi_regport.sv
module strap_spi_regport
  import spi_strap_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap_mode,
  input  logic       strap_rd_n,
  input  logic       strap_wr_n,
  input  logic [2:0] strap_cfg,
  input  logic       spi_sclk,
  input  logic       spi_cs,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic       ser_sel
);
  strap_cfg_t        cfg;
  logic [2:0]        pin_sync, pin_rst;
  logic              reg_we, reg_re;
  logic [ADDR_W-1:0] reg_waddr, reg_raddr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;

  strap_capture #(.MODE_W(2)) u_straps (
    .clk        (clk),
    .rst        (rst),
    .mode_strap (strap_mode),
    .rd_strap_n (strap_rd_n),
    .wr_strap_n (strap_wr_n),
    .cfg_strap  (strap_cfg),
    .ser_sel    (ser_sel),
    .cfg        (cfg)
  );

  // Reset the synchronisers to the idle pin levels so no edge is seen at release.
  assign pin_rst = {~strap_cfg[2], strap_cfg[0], 1'b0};

  bit_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (pin_rst),
    .d       ({spi_cs, spi_sclk, spi_mosi}),
    .q       (pin_sync)
  );

  spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .en      (ser_sel),
    .cfg     (cfg),
    .sclk_s  (pin_sync[1]),
    .cs_s    (pin_sync[2]),
    .mosi_s  (pin_sync[0]),
    .rdata   (reg_rdata),
    .re      (reg_re),
    .raddr   (reg_raddr),
    .we      (reg_we),
    .waddr   (reg_waddr),
    .wdata   (reg_wdata),
    .miso    (spi_miso),
    .miso_oe (spi_miso_oe)
  );

  reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .we    (reg_we),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .re    (reg_re),
    .raddr (reg_raddr),
    .rdata (reg_rdata)
  );

  AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    !ser_sel |-> (!spi_miso_oe && !reg_we && !reg_re)) else $error("active while unselected"); // R1
  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    $past(rst) |-> (!spi_miso_oe && !spi_miso)) else $error("outputs live in reset"); // R11
endmodule

// File: tb/sim_strap_spi_regport.sv
module sim_strap_spi_regport;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] strap_mode = 2'b00;
  logic       strap_rd_n = 1'b0;
  logic       strap_wr_n = 1'b0;
  logic [2:0] strap_cfg = 3'b000;
  logic       spi_sclk = 1'b0;
  logic       spi_cs = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       spi_miso, spi_miso_oe, ser_sel;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [128];
  bit         vld [128];
  logic [2:0] cfg_cur = 3'b000;
  bit         ser_exp = 1'b0;

  always #10 clk = ~clk;

  strap_spi_regport u0 (
    .clk(clk), .rst(rst), .strap_mode(strap_mode), .strap_rd_n(strap_rd_n),
    .strap_wr_n(strap_wr_n), .strap_cfg(strap_cfg), .spi_sclk(spi_sclk),
    .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .ser_sel(ser_sel)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_miso(input logic [15:0] frm);
    if (frm[15] && vld[frm[14:8]]) return {8'h00, model[frm[14:8]]};
    return 16'h0000;
  endfunction

  task automatic do_reset(input logic [1:0] m, input logic rdn, input logic wrn, input logic [2:0] c);
    @(negedge clk);
    rst = 1'b1; strap_mode = m; strap_rd_n = rdn; strap_wr_n = wrn; strap_cfg = c;
    spi_sclk = c[0]; spi_cs = ~c[2]; spi_mosi = 1'b0;
    repeat (4) @(negedge clk);
    chk(spi_miso_oe == 1'b0 && spi_miso == 1'b0, "R11 outputs in reset", {spi_miso_oe, spi_miso}, 0);
    rst = 1'b0;
    cfg_cur = c;
    ser_exp = (m == 2'b00) && !rdn && !wrn;
    repeat (4) @(negedge clk);
    chk(ser_sel == ser_exp, "R1 ser_sel", ser_sel, ser_exp);
  endtask

  // Clocks nbits bits of frm (bits past 16 are random); returns the first 16 MISO bits.
  task automatic frame(input logic [15:0] frm, input int nbits, input int hp, output logic [15:0] got);
    got = '0;
    spi_cs = cfg_cur[2];
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? frm[15-i] : 1'($urandom);
      if (!cfg_cur[1]) begin
        spi_mosi = b;
        repeat (hp) @(negedge clk);
        if (i == 0) chk(spi_miso_oe == ser_exp, "R8 R4 oe on select", spi_miso_oe, ser_exp);
        if (i < 16) got[15-i] = spi_miso;
        spi_sclk = ~cfg_cur[0];
        repeat (hp) @(negedge clk);
        spi_sclk = cfg_cur[0];
      end else begin
        if (i == 0) begin
          repeat (hp) @(negedge clk);
          chk(spi_miso_oe == ser_exp, "R8 R4 oe on select", spi_miso_oe, ser_exp);
        end
        spi_sclk = ~cfg_cur[0];
        spi_mosi = b;
        repeat (hp) @(negedge clk);
        if (i < 16) got[15-i] = spi_miso;
        spi_sclk = cfg_cur[0];
        repeat (hp) @(negedge clk);
      end
    end
    repeat (hp) @(negedge clk);
    spi_cs = ~cfg_cur[2];
    repeat (12) @(negedge clk);
    chk(spi_miso_oe == 1'b0, "R8 oe off after deselect", spi_miso_oe, 0);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input int hp);
    logic [15:0] got;
    frame({1'b0, a, d}, 16, hp, got);
    chk(got == 16'h0000, "R7 miso zero on write", got, 0);
    if (ser_exp) begin model[a] = d; vld[a] = 1'b1; end
  endtask

  task automatic rd(input logic [6:0] a, input int hp, input string tag);
    logic [15:0] got, exp;
    exp = exp_miso({1'b1, a, 8'h00});
    frame({1'b1, a, 8'h00}, 16, hp, got);
    chk(got == exp, tag, got, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] got;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 128; k++) begin model[k] = 8'h00; vld[k] = 1'b0; end

    // Directed: default straps, basic write/read (R6, R7).
    do_reset(2'b00, 1'b0, 1'b0, 3'b000);
    wr(7'h05, 8'hA5, 8);
    rd(7'h05, 8, "R6 R7 read back");
    wr(7'h7F, 8'h3C, 7);
    rd(7'h7F, 7, "R6 R7 top address");

    // R9: frame cut after 12 bits must not write; after 5 bits nothing lingers.
    frame({1'b0, 7'h05, 8'h11}, 12, 8, got);
    rd(7'h05, 8, "R9 abort after 12 bits");
    frame({1'b1, 7'h7F, 8'h00}, 5, 8, got);
    rd(7'h7F, 8, "R9 fresh frame after 5-bit abort");

    // R10: 20-bit window writes the first 16 bits' data once.
    frame({1'b0, 7'h22, 8'h96}, 20, 8, got);
    model[7'h22] = 8'h96; vld[7'h22] = 1'b1;
    rd(7'h22, 8, "R10 overrun frame");

    // R1: not serial (mode 01, or strobes high): traffic ignored.
    do_reset(2'b01, 1'b0, 1'b0, 3'b000);
    wr(7'h05, 8'hFF, 8);
    do_reset(2'b00, 1'b1, 1'b0, 3'b000);
    wr(7'h05, 8'hEE, 8);
    do_reset(2'b00, 1'b0, 1'b0, 3'b000);
    rd(7'h05, 8, "R1 no write while unselected");

    // R5: straps moving after reset release change nothing.
    do_reset(2'b00, 1'b0, 1'b0, 3'b110);
    @(negedge clk);
    strap_cfg = 3'b001; strap_mode = 2'b11; strap_rd_n = 1'b1; strap_wr_n = 1'b1;
    wr(7'h40, 8'h5A, 8);
    rd(7'h40, 8, "R5 straps changed after reset");
    chk(ser_sel == 1'b1, "R5 ser_sel held", ser_sel, 1);

    // Random: every strap combination (R2 R3 R4), random ops and half-periods.
    for (int c = 0; c < 8; c++) begin
      do_reset(2'b00, 1'b0, 1'b0, 3'(c));
      for (int n = 0; n < 8; n++) begin
        logic [6:0] a;
        int hp;
        a  = 7'($urandom_range(0, 15));
        hp = int'($urandom_range(6, 10));
        if ($urandom_range(0, 1) == 1 && vld[a])
          rd(a, hp, "R7 R2 R3 R4 random read");
        else
          wr(a, 8'($urandom), hp);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule